// File: doc/BRIEF.md
# SDRAM Auto-Precharge Bank Tracker

This block sits in a memory controller beside the command scheduler. It watches the registered command stream (command code, auto-precharge flag, bank and column) and keeps a small state machine for every bank. The state machine follows each write burst beat by beat. When a read or write to another open bank cuts the burst short, the block stops marking beats and times the interrupted bank's write recovery from the cycle of that interrupting command. It then times that bank's precharge and returns the bank to idle. The interrupting bank runs its own sequence at the same time, independently.

The scheduler uses the per-bank state outputs to know when a bank can be used again. Downstream data logic uses three further outputs: the per-cycle beat strobe with its bank and column, the per-bank captured-beat mask, and the read-data window.

Command codes on `cmd_i`: 0 = NOP, 1 = ACTIVE, 2 = READ, 3 = WRITE. Bank state codes (3 bits per bank, bank b at bits `3b+2:3b`): 0 = idle, 1 = page active, 2 = write burst, 3 = write recovery, 4 = precharging. Cycle offsets below count from the cycle in which a command is presented on the inputs. The defaults are a burst of 4, tWR = 2, tRP = 3 and CAS latency 3.

Top module: `ap_bank_tracker`

## Requirements
- R1: While `rst_ni` is low, and after it rises, every bank reads state 0, every mask bit is 0, and `viol_o`, `rd_valid_o` and `beat_vld_o` are 0.
- R2: An ACTIVE moves an idle bank to state 1 in the next cycle. A READ or WRITE to an idle bank produces no beat, no read window and no state change.
- R3: A WRITE to an open bank (state 1 or 2) at offset 0 strobes `beat_vld_o` with that bank at offsets 0..3. The columns wrap inside the aligned group of 4: column bits [1:0] are the start value plus the offset modulo 4, and the upper bits are unchanged.
- R4: A READ or WRITE to a different open bank at offset d (1..3) cuts the burst. The burst bank still reads state 2 at offset d, does not own the beat of offset d, and has left state 2 at offset d+1.
- R5: In the burst bank's 4-bit mask, bit i is set exactly when the beat at offset i was captured: bits 0..d-1 after a cut at offset d, and all four bits otherwise.
- R6: An auto-precharge write enters state 3 at offset d+1 when cut at offset d, or at offset 4 when not cut, and stays in state 3 for tWR cycles.
- R7: After write recovery the bank is in state 4 for tRP cycles, then in state 0.
- R8: A write without auto-precharge returns its bank to state 1 at offset 4, or at offset d+1 when cut at offset d.
- R9: An accepted READ at offset j sets `rd_valid_o` for offsets j+CAS..j+CAS+3 and at no other time.
- R10: The interrupting bank's own write proceeds unaffected: it reads state 2 for the next three cycles and strobes its own four beats.
- R11: Any non-NOP command to a bank in state 3 or 4 is ignored: it gives no beat, no read window and no change of state. `viol_o` rises in the next cycle and stays high until reset.
- R12: A READ with auto-precharge at offset 0 keeps its bank in state 1 until offset 3 and in state 4 from offset 4 for tRP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command code: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE |
| ap_i | input | 1 | Auto-precharge flag for READ or WRITE |
| bank_i | input | BANK_W | Target bank |
| col_i | input | COL_W | Start column |
| bank_state_o | output | 3*NUM_BANKS | Packed per-bank state codes |
| wr_mask_o | output | NUM_BANKS*BURST_LEN | Per-bank mask of captured beats of the latest write |
| beat_vld_o | output | 1 | A write beat is captured in this cycle |
| beat_bank_o | output | BANK_W | Bank of the current beat |
| beat_col_o | output | COL_W | Column of the current beat |
| rd_valid_o | output | 1 | Read data window |
| viol_o | output | 1 | Sticky protocol-violation flag |

## Verification
The hardest case is a cut that lands in a particular beat of the burst while the interrupting bank is already open. Reaching it takes two ACTIVE commands, then a write with auto-precharge, then a read or write to the other bank at exactly offset 1, 2 or 3. The bench sweeps every ordered pair of distinct banks, every cut offset (plus the uncut case) and both interrupting commands. For each run it follows both banks for about twenty cycles, and the expected states, beats, columns and read windows are computed from the offset.

// File: rtl/ap_trk_pkg.sv
package ap_trk_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE   = 3'd0,
    BK_ACTIVE = 3'd1,
    BK_WRITE  = 3'd2,
    BK_WREC   = 3'd3,
    BK_PRE    = 3'd4
  } bank_st_e;
endpackage

// File: rtl/ap_rd_pipe.sv
module ap_rd_pipe #(
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  output logic valid_o
);
  localparam int CW = $clog2(BURST_LEN);

  logic [CAS_LAT-1:0] sr_q, sr_d;
  logic [CW-1:0]      rcnt_q;

  if (CAS_LAT > 1) begin : g_shift
    assign sr_d = {sr_q[CAS_LAT-2:0], rd_i};
  end else begin : g_single
    assign sr_d = rd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      rcnt_q <= '0;
    end else begin
      sr_q <= sr_d;
      if (sr_q[CAS_LAT-1])  rcnt_q <= CW'(BURST_LEN - 1);
      else if (rcnt_q != 0) rcnt_q <= rcnt_q - 1'b1;
    end
  end

  assign valid_o = sr_q[CAS_LAT-1] | (rcnt_q != 0);
endmodule

// File: rtl/ap_bank_fsm.sv
module ap_bank_fsm
  import ap_trk_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int COL_W     = 8,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [1:0]       cmd_i,
  input  logic             ap_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             intr_i,
  output logic [2:0]       st_o,
  output logic [BURST_LEN-1:0] mask_o,
  output logic             acc_rw_o,
  output logic             viol_o,
  output logic             beat_vld_o,
  output logic [COL_W-1:0] beat_col_o
);
  localparam int BEAT_W  = $clog2(BURST_LEN);
  localparam int MAX_A   = (T_WR > T_RP) ? T_WR : T_RP;
  localparam int CNT_MAX = (MAX_A > BURST_LEN) ? MAX_A : BURST_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  bank_st_e             st_q, st_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 ap_q, ap_d, rpend_q, rpend_d;
  logic [COL_W-1:0]     col_q, col_d;
  logic [BURST_LEN-1:0] mask_q, mask_d;
  cmd_e                 cmd;
  logic                 is_open, rw;

  assign cmd      = cmd_e'(cmd_i);
  assign is_open  = (st_q == BK_ACTIVE) || (st_q == BK_WRITE);
  assign rw       = hit_i && ((cmd == CMD_RD) || (cmd == CMD_WR));
  assign acc_rw_o = rw && is_open;
  assign viol_o   = hit_i && (cmd != CMD_NOP) && ((st_q == BK_WREC) || (st_q == BK_PRE));

  // burst-aligned column wrap
  function automatic logic [COL_W-1:0] wrap_col(input logic [COL_W-1:0] base,
                                                input logic [BEAT_W-1:0] off);
    return {base[COL_W-1:BEAT_W], base[BEAT_W-1:0] + off};
  endfunction

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    ap_d       = ap_q;
    rpend_d    = rpend_q;
    col_d      = col_q;
    mask_d     = mask_q;
    beat_vld_o = 1'b0;
    beat_col_o = col_q;
    if (acc_rw_o && cmd == CMD_WR) begin
      st_d       = BK_WRITE;
      cnt_d      = CNT_W'(1);
      ap_d       = ap_i;
      col_d      = col_i;
      mask_d     = BURST_LEN'(1);
      rpend_d    = 1'b0;
      beat_vld_o = 1'b1;
      beat_col_o = col_i;
    end else if (acc_rw_o) begin
      st_d    = BK_ACTIVE;
      rpend_d = ap_i;
      cnt_d   = CNT_W'(BURST_LEN - 1);
    end else begin
      case (st_q)
        BK_IDLE: if (hit_i && cmd == CMD_ACT) begin
          st_d    = BK_ACTIVE;
          rpend_d = 1'b0;
        end
        BK_ACTIVE: if (rpend_q) begin
          if (cnt_q == CNT_W'(1)) begin
            st_d    = BK_PRE;
            cnt_d   = CNT_W'(T_RP);
            rpend_d = 1'b0;
          end else cnt_d = cnt_q - 1'b1;
        end
        BK_WRITE: if (intr_i) begin
          st_d  = ap_q ? BK_WREC : BK_ACTIVE;
          cnt_d = CNT_W'(T_WR);
        end else begin
          beat_vld_o = 1'b1;
          beat_col_o = wrap_col(col_q, cnt_q[BEAT_W-1:0]);
          mask_d[cnt_q[BEAT_W-1:0]] = 1'b1;
          if (cnt_q == CNT_W'(BURST_LEN - 1)) begin
            st_d  = ap_q ? BK_WREC : BK_ACTIVE;
            cnt_d = CNT_W'(T_WR);
          end else cnt_d = cnt_q + 1'b1;
        end
        BK_WREC: if (cnt_q == CNT_W'(1)) begin
          st_d  = BK_PRE;
          cnt_d = CNT_W'(T_RP);
        end else cnt_d = cnt_q - 1'b1;
        BK_PRE: if (cnt_q == CNT_W'(1)) st_d = BK_IDLE;
                else cnt_d = cnt_q - 1'b1;
        default: st_d = BK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BK_IDLE;
      cnt_q   <= '0;
      ap_q    <= 1'b0;
      rpend_q <= 1'b0;
      col_q   <= '0;
      mask_q  <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      ap_q    <= ap_d;
      rpend_q <= rpend_d;
      col_q   <= col_d;
      mask_q  <= mask_d;
    end
  end

  assign st_o   = st_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/ap_bank_tracker.sv
module ap_bank_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int COL_W     = 8,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3,
  parameter int CAS_LAT   = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [1:0]                     cmd_i,
  input  logic                           ap_i,
  input  logic [BANK_W-1:0]              bank_i,
  input  logic [COL_W-1:0]               col_i,
  output logic [3*NUM_BANKS-1:0]         bank_state_o,
  output logic [NUM_BANKS*BURST_LEN-1:0] wr_mask_o,
  output logic                           beat_vld_o,
  output logic [BANK_W-1:0]              beat_bank_o,
  output logic [COL_W-1:0]               beat_col_o,
  output logic                           rd_valid_o,
  output logic                           viol_o
);
  logic [NUM_BANKS-1:0] acc, vpulse, bvld, intr;
  logic [COL_W-1:0]     bcol [NUM_BANKS];
  logic                 viol_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign intr[b] = |(acc & ~(NUM_BANKS'(1) << b));
    ap_bank_fsm #(
      .BURST_LEN(BURST_LEN), .COL_W(COL_W), .T_WR(T_WR), .T_RP(T_RP)
    ) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hit_i      ((cmd_i != 2'd0) && (bank_i == BANK_W'(b))),
      .cmd_i      (cmd_i),
      .ap_i       (ap_i),
      .col_i      (col_i),
      .intr_i     (intr[b]),
      .st_o       (bank_state_o[3*b +: 3]),
      .mask_o     (wr_mask_o[BURST_LEN*b +: BURST_LEN]),
      .acc_rw_o   (acc[b]),
      .viol_o     (vpulse[b]),
      .beat_vld_o (bvld[b]),
      .beat_col_o (bcol[b])
    );
  end

  // at most one bank bursts at a time
  always_comb begin
    beat_vld_o  = 1'b0;
    beat_bank_o = '0;
    beat_col_o  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bvld[b]) begin
        beat_vld_o  = 1'b1;
        beat_bank_o = BANK_W'(b);
        beat_col_o  = bcol[b];
      end
    end
  end

  ap_rd_pipe #(.CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    ((cmd_i == 2'd2) && (|acc)),
    .valid_o (rd_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= viol_q | (|vpulse);
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/ap_bank_tracker_chk.sv
module ap_bank_tracker_chk #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             cmd_i,
  input logic [BANK_W-1:0]      bank_i,
  input logic [3*NUM_BANKS-1:0] bank_state_o,
  input logic                   beat_vld_o,
  input logic                   viol_o
);
  logic [2:0]           st [NUM_BANKS];
  logic [NUM_BANKS-1:0] in_wr;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_st
    assign st[b]    = bank_state_o[3*b +: 3];
    assign in_wr[b] = (st[b] == 3'd2);
  end

  assert_viol_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o);

  assert_one_writer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_wr));

  assert_beat_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_vld_o |-> (cmd_i == 2'd3) || (|in_wr));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assert_wrec_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st[b] == 3'd3) |=> (st[b] == 3'd3) || (st[b] == 3'd4));
    assert_pre_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st[b] == 3'd4) |=> (st[b] == 3'd4) || (st[b] == 3'd0));
    assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((st[b] == 3'd0) && !((cmd_i == 2'd1) && (bank_i == BANK_W'(b)))) |=> (st[b] == 3'd0));
    for (genvar m = 0; m < NUM_BANKS; m++) begin : g_other
      if (m != b) begin : g_pair
        assert_cut_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
          ((st[b] == 3'd2) && ((st[m] == 3'd1) || (st[m] == 3'd2)) &&
           (bank_i == BANK_W'(m)) && cmd_i[1]) |=> (st[b] != 3'd2));
      end
    end
  end
endmodule

bind ap_bank_tracker ap_bank_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_i        (cmd_i),
  .bank_i       (bank_i),
  .bank_state_o (bank_state_o),
  .beat_vld_o   (beat_vld_o),
  .viol_o       (viol_o)
);

// File: tb/sim_ap_bank_tracker.sv
module sim_ap_bank_tracker;
  localparam int TWR = 2, TRP = 3, CL = 3, BL = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cmd = 2'd0, bank = 2'd0;
  logic       ap = 1'b0;
  logic [7:0] col = 8'd0;
  logic [11:0] st_o;
  logic [15:0] mask_o;
  logic        bvld, rdv, viol;
  logic [1:0]  bbank;
  logic [7:0]  bcol;
  int n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  ap_bank_tracker u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .ap_i(ap), .bank_i(bank), .col_i(col),
    .bank_state_o(st_o), .wr_mask_o(mask_o), .beat_vld_o(bvld), .beat_bank_o(bbank),
    .beat_col_o(bcol), .rd_valid_o(rdv), .viol_o(viol)
  );

  task automatic chk(input int act, input int exp, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int st_of(input int b);
    return int'(st_o[3*b +: 3]);
  endfunction

  function automatic int mask_of(input int b);
    return int'(mask_o[4*b +: 4]);
  endfunction

  function automatic int wcol(input int base, input int off);
    return (base & 'hFC) | ((base + off) & 3);
  endfunction

  // present inputs for one cycle; outputs are then sampled in that cycle
  task automatic drive(input int c, input int a, input int b, input int cl);
    @(negedge clk);
    cmd = 2'(c); ap = a[0]; bank = 2'(b); col = 8'(cl);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    cmd = 2'd0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk_beat(input int v, input int b, input int c, input string tag);
    chk(int'(bvld), v, {tag, " beat valid"});
    if (v != 0) begin
      chk(int'(bbank), b, {tag, " beat bank"});
      chk(int'(bcol), c, {tag, " beat column"});
    end
  endtask

  // n: burst bank, m: interrupter, d: cut offset (4 = none), kind: 2 READ / 3 WRITE
  task automatic scen(input int n, input int m, input int d, input int kind);
    int a, c, ws, exp_st, exp_m;
    a = (n * 53 + m * 17 + d * 5 + kind) & 255;
    c = a ^ 'h81;
    ws = (d < 4) ? d + 1 : 4;
    do_reset();
    drive(1, 0, n, 0);
    drive(1, 0, m, 0);
    drive(3, 1, n, a);
    chk_beat(1, n, a, "R3");
    for (int i = 1; i <= 20; i++) begin
      if (i == d && d < 4) drive(kind, 0, m, c);
      else drive(0, 0, 0, 0);
      if (i < ws) exp_st = 2;
      else if (i < ws + TWR) exp_st = 3;
      else if (i < ws + TWR + TRP) exp_st = 4;
      else exp_st = 0;
      chk(st_of(n), exp_st, (i < ws) ? "R4 burst bank state" :
                            (i < ws + TWR) ? "R6 recovery state" : "R7 precharge/idle state");
      if (i < d && i < 4) chk_beat(1, n, wcol(a, i), "R3");
      else if (d < 4 && kind == 3 && i < d + 4) chk_beat(1, m, wcol(c, i - d), "R10");
      else chk_beat(0, 0, 0, "R4");
      chk(int'(rdv), (kind == 2 && d < 4 && i >= d + CL && i < d + CL + BL) ? 1 : 0,
          "R9 read window");
      exp_m = (kind == 3 && d < 4 && i > d && i <= d + 3) ? 2 : 1;
      chk(st_of(m), exp_m, "R10 interrupter state");
      if (i == ws) chk(mask_of(n), (d < 4) ? ((1 << d) - 1) : 15, "R5 captured mask");
    end
    chk(int'(viol), 0, "R11 no violation on legal stream");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    drive(0, 0, 0, 0);
    for (int b = 0; b < 4; b++) begin
      chk(st_of(b), 0, "R1 bank state");
      chk(mask_of(b), 0, "R1 mask");
    end
    chk(int'(viol), 0, "R1 violation");
    chk(int'(rdv), 0, "R1 read window");
    chk(int'(bvld), 0, "R1 beat");

    // R2 commands to an idle bank
    drive(3, 1, 2, 8'h10);
    chk(int'(bvld), 0, "R2 write to idle bank");
    drive(2, 0, 2, 0);
    chk(st_of(2), 0, "R2 idle after write");
    drive(1, 0, 2, 0);
    chk(st_of(2), 0, "R2 idle before open");
    drive(0, 0, 0, 0);
    chk(st_of(2), 1, "R2 opened");
    for (int i = 0; i < 6; i++) begin
      drive(0, 0, 0, 0);
      chk(int'(rdv), 0, "R2 read to idle bank ignored");
    end

    // sweep: all ordered pairs, all cut offsets, both interrupter kinds
    for (int n = 0; n < 4; n++)
      for (int m = 0; m < 4; m++)
        if (n != m)
          for (int d = 1; d <= 4; d++)
            for (int k = 2; k <= 3; k++)
              scen(n, m, d, k);

    // R8 plain write, not cut
    do_reset();
    drive(1, 0, 1, 0);
    drive(3, 0, 1, 8'h3E);
    for (int i = 1; i <= 6; i++) begin
      drive(0, 0, 0, 0);
      chk(st_of(1), (i < 4) ? 2 : 1, "R8 plain write state");
    end
    chk(mask_of(1), 15, "R8 full mask");

    // R8 plain write cut at offset 2
    do_reset();
    drive(1, 0, 0, 0);
    drive(1, 0, 1, 0);
    drive(3, 0, 0, 8'h21);
    drive(0, 0, 0, 0);
    drive(2, 0, 1, 0);
    chk(st_of(0), 2, "R8 still bursting");
    drive(0, 0, 0, 0);
    chk(st_of(0), 1, "R8 back to active after cut");
    chk(mask_of(0), 3, "R5 mask after plain cut");

    // R11 commands during recovery and precharge
    do_reset();
    drive(1, 0, 0, 0);
    drive(3, 1, 0, 8'h40);
    for (int i = 1; i <= 3; i++) drive(0, 0, 0, 0);
    drive(3, 0, 0, 8'h55);
    chk(st_of(0), 3, "R11 in recovery");
    chk(int'(bvld), 0, "R11 write in recovery ignored");
    drive(0, 0, 0, 0);
    chk(int'(viol), 1, "R11 flag raised");
    chk(st_of(0), 3, "R11 recovery unchanged");
    drive(0, 0, 0, 0);
    chk(st_of(0), 4, "R11 precharge");
    drive(2, 0, 0, 0);
    chk(st_of(0), 4, "R11 read in precharge");
    for (int i = 8; i <= 12; i++) begin
      drive(0, 0, 0, 0);
      chk(int'(rdv), 0, "R11 read in precharge ignored");
      chk(st_of(0), (i < 9) ? 4 : 0, "R11 precharge timing kept");
      chk(int'(viol), 1, "R11 flag sticky");
    end
    do_reset();
    drive(0, 0, 0, 0);
    chk(int'(viol), 0, "R1 flag cleared by reset");

    // R12 read with auto-precharge
    drive(1, 0, 3, 0);
    drive(2, 1, 3, 8'h07);
    for (int i = 1; i <= 9; i++) begin
      drive(0, 0, 0, 0);
      chk(st_of(3), (i < 4) ? 1 : (i < 4 + TRP) ? 4 : 0, "R12 read-precharge state");
      chk(int'(rdv), (i >= CL && i < CL + BL) ? 1 : 0, "R9 read window after read");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule